// File: doc/BRIEF.md
# DRAM refresh and initialization scheduler

This block sits next to the access sequencer of an asynchronous DRAM controller and takes charge of keeping the array refreshed. After reset it holds both strobes high for a power-up pause. It then runs a fixed number of CAS-before-RAS warm-up cycles on its own and raises `ready`. The sequencer must leave the bus alone until `ready` is high.

In normal operation an internal interval timer adds one owed refresh each period. With the default period of 1560 cycles at 100 MHz, 2048 refreshes fit within 32 ms. While a refresh is owed, the scheduler asks for the bus with `bus_req`. It waits until `grant` is high and `row_open` is low, lets the row precharge, and drives one CAS-before-RAS cycle. The row address comes from the device's own counter. The scheduler then holds the bus through a trailing precharge and releases it.

When owed refreshes pile up to a limit, `urgent` tells the sequencer to give refresh priority. A low-power request moves the device into self-refresh. On exit the scheduler honours the minimum low time and the exit precharge, then restarts its refresh schedule.

All timing parameters are given in clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset is released, `ras_n` and `cas_n` stay high and `ready` stays low for PAUSE_CYC cycles.
- R2: After the pause, exactly INIT_CYC CAS-before-RAS cycles run without `bus_req`. `ready` then rises and stays high until the next reset. `bus_req` is never high while `ready` is low.
- R3: In every CAS-before-RAS cycle, `cas_n` (active low) falls CSR_CYC cycles before `ras_n` (active low). `cas_n` stays low CHR_CYC cycles after `ras_n` falls. `ras_n` stays low RAS_CYC cycles in total. `we_n` is always high.
- R4: Both strobes are high for at least RP_CYC cycles before every fall of `cas_n`. After each refresh they stay high RP_CYC cycles before the bus is released.
- R5: Once `ready` is high, one owed refresh is added every REF_INT cycles, except while the self-refresh hold or exit phases are in progress.
- R6: From idle, with a refresh owed, `bus_req` rises one cycle later. No strobe moves until `grant` is high and `row_open` is low, and the RP_CYC precharge is then counted from that point. `bus_req` stays high until the trailing precharge ends, and that completion removes one owed refresh.
- R7: `urgent` is high exactly when the owed count equals MAX_OWED. A timer expiry while the count is already at MAX_OWED is dropped.
- R8: When idle with `lowpwr_req` high, self-refresh is chosen over an owed refresh. After the grant and the precharge, `cas_n` falls CSR_CYC cycles before `ras_n`, and `in_self` is high while both strobes are low.
- R9: During self-refresh, `ras_n` stays low for at least SR_RAS_CYC cycles and until `lowpwr_req` is low.
- R10: On self-refresh exit, both strobes are high for SR_RPS_CYC cycles while `bus_req` is still held. The owed count is then cleared and the interval timer restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant | input | 1 | Sequencer hands the DRAM bus to the scheduler |
| row_open | input | 1 | Sequencer still has a row active; refresh must wait |
| lowpwr_req | input | 1 | Request to enter and stay in self-refresh |
| bus_req | output | 1 | Scheduler wants or holds the bus |
| urgent | output | 1 | Owed refreshes at the limit; refresh needs priority |
| ready | output | 1 | Pause and warm-up cycles are complete |
| in_self | output | 1 | Device is held in self-refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high during refresh |

## Verification
A wrong phase count shows within one cycle as a strobe edge that comes early or late. A lost or doubled owed refresh shows as an extra or missing `bus_req` window one interval later, or as `urgent` rising at the wrong count. A wrong self-refresh hold shows when `ras_n` rises before the minimum. A timer that is not restarted after exit shifts the next refresh request. The bench model tracks the owed count and the timer on its own and compares every output on every cycle, so any of these shows in the cycle it happens.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int PAUSE_CYC  = 20000,
  parameter int INIT_CYC   = 8,
  parameter int REF_INT    = 1560,
  parameter int MAX_OWED   = 8,
  parameter int RP_CYC     = 3,
  parameter int CSR_CYC    = 1,
  parameter int CHR_CYC    = 1,
  parameter int RAS_CYC    = 5,
  parameter int SR_RAS_CYC = 10000,
  parameter int SR_RPS_CYC = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  logic row_open,
  input  logic lowpwr_req,
  output logic bus_req,
  output logic urgent,
  output logic ready,
  output logic in_self,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int RSH_CYC = RAS_CYC - CHR_CYC;
  localparam int M1 = (PAUSE_CYC > SR_RAS_CYC) ? PAUSE_CYC : SR_RAS_CYC;
  localparam int M2 = (RP_CYC > SR_RPS_CYC) ? RP_CYC : SR_RPS_CYC;
  localparam int M3 = (RSH_CYC > CHR_CYC) ? RSH_CYC : CHR_CYC;
  localparam int M4 = (M1 > M2) ? M1 : M2;
  localparam int M5 = (M3 > CSR_CYC) ? M3 : CSR_CYC;
  localparam int CNT_MAX = (M4 > M5) ? M4 : M5;
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam int TW = $clog2(REF_INT + 1);
  localparam int OW = $clog2(MAX_OWED + 1);
  localparam int IW = $clog2(INIT_CYC + 1);

  typedef enum logic [3:0] {
    S_PAUSE, S_CSR, S_CHR, S_RSH, S_TAIL, S_IDLE, S_WAIT, S_PRE, S_SELF, S_SRX
  } st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt;
  logic [IW-1:0] icnt;
  logic [TW-1:0] tmr;
  logic [OW-1:0] owed, owed_nx;
  logic rdy, sel;
  logic run, tick, done, srx_end, cnt_z;

  function automatic logic [CW-1:0] len_of(input st_t s);
    case (s)
      S_PAUSE: len_of = CW'(PAUSE_CYC - 1);
      S_CSR:   len_of = CW'(CSR_CYC - 1);
      S_CHR:   len_of = CW'(CHR_CYC - 1);
      S_RSH:   len_of = CW'(RSH_CYC - 1);
      S_TAIL:  len_of = CW'(RP_CYC - 1);
      S_PRE:   len_of = CW'(RP_CYC - 1);
      S_SELF:  len_of = CW'(SR_RAS_CYC - 1);
      S_SRX:   len_of = CW'(SR_RPS_CYC - 1);
      default: len_of = '0;
    endcase
  endfunction

  assign cnt_z = (cnt == '0);

  always_comb begin
    nxt = st;
    case (st)
      S_PAUSE: if (cnt_z) nxt = S_CSR;
      S_CSR:   if (cnt_z) nxt = sel ? S_SELF : S_CHR;
      S_CHR:   if (cnt_z) nxt = S_RSH;
      S_RSH:   if (cnt_z) nxt = S_TAIL;
      S_TAIL:  if (cnt_z) nxt = (rdy || icnt == IW'(INIT_CYC - 1)) ? S_IDLE : S_CSR;
      S_IDLE:  if (owed != '0 || lowpwr_req) nxt = S_WAIT;
      S_WAIT:  if (grant && !row_open) nxt = S_PRE;
      S_PRE:   if (cnt_z) nxt = S_CSR;
      S_SELF:  if (cnt_z && !lowpwr_req) nxt = S_SRX;
      S_SRX:   if (cnt_z) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign run     = rdy && st != S_SELF && st != S_SRX;
  assign tick    = run && tmr == TW'(REF_INT - 1);
  assign done    = rdy && st == S_TAIL && cnt_z;
  assign srx_end = st == S_SRX && cnt_z;

  always_comb begin
    owed_nx = owed;
    if (tick && !done && owed != OW'(MAX_OWED)) owed_nx = owed + OW'(1);
    else if (done && !tick) owed_nx = owed - OW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_PAUSE;
      cnt  <= len_of(S_PAUSE);
      icnt <= '0;
      rdy  <= 1'b0;
      sel  <= 1'b0;
      tmr  <= '0;
      owed <= '0;
    end else begin
      st  <= nxt;
      cnt <= (nxt != st) ? len_of(nxt) : (cnt_z ? cnt : cnt - CW'(1));
      if (st == S_TAIL && cnt_z && !rdy) begin
        icnt <= icnt + IW'(1);
        if (icnt == IW'(INIT_CYC - 1)) rdy <= 1'b1;
      end
      if (st == S_IDLE && nxt == S_WAIT) sel <= lowpwr_req;
      if (srx_end) begin
        tmr  <= '0;
        owed <= '0;
      end else begin
        if (run) tmr <= tick ? '0 : tmr + TW'(1);
        owed <= owed_nx;
      end
    end
  end

  assign ready   = rdy;
  assign bus_req = rdy && st != S_IDLE;
  assign urgent  = owed == OW'(MAX_OWED);
  assign in_self = st == S_SELF;
  assign ras_n   = !(st == S_CHR || st == S_RSH || st == S_SELF);
  assign cas_n   = !(st == S_CSR || st == S_CHR || st == S_SELF);
  assign we_n    = 1'b1;
endmodule

module dram_refresh_sched_chk #(
  parameter int PAUSE_CYC  = 20000,
  parameter int RP_CYC     = 3,
  parameter int CSR_CYC    = 1,
  parameter int CHR_CYC    = 1,
  parameter int RAS_CYC    = 5,
  parameter int SR_RAS_CYC = 10000
) (
  input logic clk,
  input logic rst_n,
  input logic bus_req,
  input logic urgent,
  input logic ready,
  input logic in_self,
  input logic ras_n,
  input logic cas_n
);
  logic [31:0] age, rhi, rlo, clo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= '0; rhi <= '0; rlo <= '0; clo <= '0;
    end else begin
      age <= (age == 32'hFFFF_FFFF) ? age : age + 32'd1;
      rhi <= (ras_n && cas_n) ? rhi + 32'd1 : '0;
      rlo <= !ras_n ? rlo + 32'd1 : '0;
      clo <= !cas_n ? clo + 32'd1 : '0;
    end
  end

  assert_pause_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    age < 32'(PAUSE_CYC) |-> ras_n && cas_n && !ready);
  assert_ready_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  assert_no_req_in_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !bus_req);
  assert_cas_leads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> clo >= 32'(CSR_CYC));
  assert_cas_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) && !ras_n |-> clo >= 32'(CSR_CYC + CHR_CYC));
  assert_ras_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) && !$past(in_self) |-> rlo == 32'(RAS_CYC));
  assert_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> rhi >= 32'(RP_CYC));
  assert_bus_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ready && (!ras_n || !cas_n) |-> bus_req);
  assert_urgent_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(urgent) |-> $past(bus_req));
  assert_self_strobes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_self |-> !ras_n && !cas_n);
  assert_self_min_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) && $past(in_self) |-> rlo >= 32'(SR_RAS_CYC));
  assert_self_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_self) |-> ras_n && cas_n && bus_req);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .PAUSE_CYC(PAUSE_CYC), .RP_CYC(RP_CYC), .CSR_CYC(CSR_CYC),
  .CHR_CYC(CHR_CYC), .RAS_CYC(RAS_CYC), .SR_RAS_CYC(SR_RAS_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .urgent(urgent),
  .ready(ready), .in_self(in_self), .ras_n(ras_n), .cas_n(cas_n)
);

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
  localparam int P = 20, NI = 8, RI = 40, MO = 8, RP = 2, CS = 1, CH = 2, RA = 4, SR = 15, RS = 3;

  logic clk = 0, rst_n = 0, grant = 0, row_open = 0, lowpwr_req = 0;
  logic bus_req, urgent, ready, in_self, ras_n, cas_n, we_n;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  dram_refresh_sched #(.PAUSE_CYC(P), .INIT_CYC(NI), .REF_INT(RI), .MAX_OWED(MO),
    .RP_CYC(RP), .CSR_CYC(CS), .CHR_CYC(CH), .RAS_CYC(RA), .SR_RAS_CYC(SR),
    .SR_RPS_CYC(RS)) u0 (
    .clk(clk), .rst_n(rst_n), .grant(grant), .row_open(row_open), .lowpwr_req(lowpwr_req),
    .bus_req(bus_req), .urgent(urgent), .ready(ready), .in_self(in_self),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n));

  task automatic chk(input string tag, input string nm, input logic act, input logic ex);
    total++;
    if (act !== ex) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, nm, act, ex, $time);
    end
  endtask

  // behavioural reference
  int owed = 0, tmr = 0, owed_pre = 0;
  bit g_s, ro_s, lp_s, started = 0;
  logic e_ras = 1, e_cas = 1, e_req = 0, e_rdy = 0, e_self = 0;
  string ph = "R1";

  task automatic adv(input bit fin, input bit run);
    bit tk;
    @(posedge clk);
    g_s = grant; ro_s = row_open; lp_s = lowpwr_req; owed_pre = owed;
    tk = run && (tmr == RI - 1);
    if (run) tmr = tk ? 0 : tmr + 1;
    if (tk && !fin) begin if (owed < MO) owed++; end
    else if (fin && !tk) owed--;
  endtask

  task automatic expv(input logic r, input logic c, input logic q, input logic s);
    e_ras = r; e_cas = c; e_req = q; e_self = s;
  endtask

  initial begin
    bit sel;
    int n;
    wait (rst_n);
    started = 1;
    ph = "R1"; expv(1, 1, 0, 0);
    repeat (P) adv(0, 0);
    for (int i = 0; i < NI; i++) begin
      ph = "R2";
      expv(1, 0, 0, 0); repeat (CS) adv(0, 0);
      expv(0, 0, 0, 0); repeat (CH) adv(0, 0);
      expv(0, 1, 0, 0); repeat (RA - CH) adv(0, 0);
      expv(1, 1, 0, 0); repeat (RP) adv(0, 0);
    end
    e_rdy = 1;
    forever begin
      ph = "R5"; expv(1, 1, 0, 0);
      do adv(0, 1); while (!(owed_pre > 0 || lp_s));
      sel = lp_s;
      ph = "R6"; expv(1, 1, 1, 0);
      do adv(0, 1); while (!(g_s && !ro_s));
      ph = "R4"; repeat (RP) adv(0, 1);
      if (sel) begin
        ph = "R8"; expv(1, 0, 1, 0); repeat (CS) adv(0, 1);
        ph = "R9"; expv(0, 0, 1, 1); n = 0;
        do begin adv(0, 0); n++; end while (!(n >= SR && !lp_s));
        ph = "R10"; expv(1, 1, 1, 0); repeat (RS) adv(0, 0);
        owed = 0; tmr = 0;
      end else begin
        ph = "R3"; expv(1, 0, 1, 0); repeat (CS) adv(0, 1);
        expv(0, 0, 1, 0); repeat (CH) adv(0, 1);
        expv(0, 1, 1, 0); repeat (RA - CH) adv(0, 1);
        ph = "R4"; expv(1, 1, 1, 0); repeat (RP - 1) adv(0, 1);
        adv(1, 1);
      end
    end
  end

  always @(negedge clk) if (rst_n && started) begin
    chk(ph, "ras_n", ras_n, e_ras);
    chk(ph, "cas_n", cas_n, e_cas);
    chk(ph, "bus_req", bus_req, e_req);
    chk(ph, "in_self", in_self, e_self);
    chk("R2", "ready", ready, e_rdy);
    chk("R7", "urgent", urgent, owed >= MO);
    chk("R3", "we_n", we_n, 1'b1);
  end

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    cyc(1);
    chk("R1", "reset ras_n", ras_n, 1'b1);
    chk("R1", "reset ready", ready, 1'b0);
    grant = 1; row_open = 0;
    cyc(4); rst_n = 1;
    cyc(P + NI * (CS + RA + RP) + 2);
    chk("R2", "ready after warm-up", ready, 1'b1);
    cyc(400);
    grant = 0;
    cyc(450);
    chk("R7", "urgent after starved grant", urgent, 1'b1);
    grant = 1; row_open = 1;
    cyc(20);
    chk("R6", "no strobe while row open", cas_n, 1'b1);
    row_open = 0; lowpwr_req = 1;
    cyc(60);
    chk("R8", "self chosen over owed", in_self, 1'b1);
    lowpwr_req = 0;
    cyc(100);
    lowpwr_req = 1; cyc(2); lowpwr_req = 0;
    cyc(60);
    chk("R10", "out of self", in_self, 1'b0);
    cyc(300);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R2 actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule